// File: doc/BRIEF.md
# Real-Time Clock Interrupt Merger

This block gathers the three interrupt causes of a real-time clock onto one active-high request line. One cause is a programmable periodic tick. The block makes this tick itself by dividing a timebase strobe. The other two causes are pulses from neighbouring logic: the end of the once-per-second update cycle and a match of the alarm comparator. Each cause sets its own sticky flag. A flag is set whether or not its enable is on, and the request line reflects only the enabled flags.

Software talks to the block through a small register port with three registers. The rate register picks the periodic rate. The enable register masks the causes. The flag register reports what happened. Reading the flag register returns the flags and clears them. The enable bits and the flag bits occupy the same bit positions, so an interrupt handler finds the cause of a request by ANDing the flag register with the enable register.

Top module: `rtc_irq_merge`

## Requirements
- R1: Register map on the 2-bit address: 0 is the rate register (bits 3:0 hold the rate code, other bits read 0), 1 is the enable register (bit 6 periodic, bit 5 alarm, bit 4 update, other bits read 0), 2 is the flag register, and 3 reads 0. After reset all registers read 0 and `irq` is low.
- R2: With rate code n from 3 to 15 and the timebase strobe held high, a periodic event occurs every 2^(n-1) strobes. Code 3 gives a period of 4 strobes and code 15 gives a period of 16384 strobes.
- R3: Rate codes 0, 1 and 2 produce no periodic event.
- R4: The periodic divider advances only in cycles where `base_tick` is high.
- R5: A write to the rate register restarts the divider, so the first periodic event comes exactly 2^(n-1) strobes after the write edge.
- R6: An event sets its flag even when its enable is clear. The flag bits are bit 6 periodic, bit 5 alarm and bit 4 update.
- R7: `irq` is high exactly when some flag and its enable bit are both set. Bit 7 of the flag register reads as this same summary.
- R8: A read of the flag register returns the current flags and clears all of them in the same cycle.
- R9: An event that arrives in the same cycle as a flag register read is not lost. The read returns the old value, and the flag is set afterwards.
- R10: `irq` is a level. Setting an enable while its flag is pending raises `irq`. Clearing that enable lowers `irq` and leaves the flag in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears the flags at address 2) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| base_tick | input | 1 | Timebase strobe that drives the periodic divider |
| upd_done | input | 1 | Single-cycle pulse at the end of an update cycle |
| alarm_hit | input | 1 | Single-cycle pulse on an alarm match |
| irq | output | 1 | Merged interrupt request, active high |

## Verification
The bench builds the block with its default 4-bit rate field, which gives a 14-bit divider. It holds the timebase strobe high in every cycle, which compresses the longest period to 16384 clocks. This keeps a sweep over every rate code affordable, covering two full periods per code, including the restart after a rate write. With the same width, long windows can show that the three reserved codes stay silent. Toggling the strobe shows that the divider counts strobes and not clocks.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NSRC     = 3;
  localparam int FLAG_LSB = 4;
  localparam int SUM_BIT  = 7;

  localparam int SRC_UPD   = 0;
  localparam int SRC_ALARM = 1;
  localparam int SRC_PER   = 2;

  typedef enum logic [1:0] {
    REG_RATE = 2'd0,
    REG_ENA  = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rtc_irq_rate_div.sv
module rtc_irq_rate_div #(
  parameter int RS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            tick,
  input  logic [RS_W-1:0] rate,
  output logic            per_evt
);
  localparam int CNT_W = (1 << RS_W) - 2;

  function automatic logic [RS_W-1:0] shift_of(input logic [RS_W-1:0] rs);
    if (rs < RS_W'(3)) return '0;
    return rs - RS_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [RS_W-1:0]  k;
  logic             rate_on;

  always_comb begin
    k       = shift_of(rate);
    rate_on = (k != '0);
    mask    = ~({CNT_W{1'b1}} << k);
  end

  assign per_evt = tick && rate_on && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  assert_silent_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate < RS_W'(3)) |-> !per_evt);

  assert_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> tick);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr,
  input  logic [NSRC-1:0] ena,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  logic [NSRC-1:0] flag_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (evt[i]) flag_q[i] <= 1'b1;
      else if (clr)    flag_q[i] <= 1'b0;
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & ena);

  assert_evt_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (evt == '0)) |=> (flag_q == '0));

  assert_collision_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (|evt)) |=> (flag_q == $past(evt)));
endmodule

// File: rtl/rtc_irq_merge.sv
module rtc_irq_merge
  import rtc_irq_pkg::*;
#(
  parameter int RS_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              base_tick,
  input  logic              upd_done,
  input  logic              alarm_hit,
  output logic              irq
);
  reg_sel_e        sel;
  logic [RS_W-1:0] rate_q;
  logic [NSRC-1:0] ena_q;
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] flags;
  logic            per_evt;
  logic            rate_wr;
  logic            ena_wr;
  logic            flag_rd;

  assign sel     = reg_sel_e'(bus_addr);
  assign rate_wr = bus_wr && (sel == REG_RATE);
  assign ena_wr  = bus_wr && (sel == REG_ENA);
  assign flag_rd = bus_rd && (sel == REG_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      ena_q  <= '0;
    end else begin
      if (rate_wr) rate_q <= bus_wdata[RS_W-1:0];
      if (ena_wr)  ena_q  <= bus_wdata[FLAG_LSB +: NSRC];
    end
  end

  rtc_irq_rate_div #(.RS_W(RS_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rate_wr),
    .tick    (base_tick),
    .rate    (rate_q),
    .per_evt (per_evt)
  );

  always_comb begin
    evt_vec            = '0;
    evt_vec[SRC_UPD]   = upd_done;
    evt_vec[SRC_ALARM] = alarm_hit;
    evt_vec[SRC_PER]   = per_evt;
  end

  rtc_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_vec),
    .clr   (flag_rd),
    .ena   (ena_q),
    .flags (flags),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_RATE: bus_rdata[RS_W-1:0] = rate_q;
      REG_ENA:  bus_rdata[FLAG_LSB +: NSRC] = ena_q;
      REG_FLAG: begin
        bus_rdata[FLAG_LSB +: NSRC] = flags;
        bus_rdata[SUM_BIT]          = irq;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|evt_vec) || $past(ena_wr)));

  assert_enable_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && (bus_wdata[FLAG_LSB +: NSRC] == '0)) |=> !irq);
endmodule

// File: tb/rtc_irq_merge_tb.sv
module rtc_irq_merge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       base_tick = 1'b0;
  logic       upd_done = 1'b0;
  logic       alarm_hit = 1'b0;
  logic       irq;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rtc_irq_merge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .base_tick(base_tick), .upd_done(upd_done), .alarm_hit(alarm_hit), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_upd();
    upd_done = 1'b1; @(posedge clk); #1; upd_done = 1'b0;
  endtask

  task automatic pulse_alarm();
    alarm_hit = 1'b1; @(posedge clk); #1; alarm_hit = 1'b0;
  endtask

  function automatic int period_of(input int code);
    return (code < 3) ? 0 : (1 << (code - 1));
  endfunction

  initial begin
    #(1_900_000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check("R1 irq after reset", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      check("R1 reset read", int'(v), 0);
    end

    // R1: field masks
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, v); check("R1 rate mask", int'(v), 8'h0F);
    wr_reg(2'd1, 8'hFF); rd_reg(2'd1, v); check("R1 enable mask", int'(v), 8'h70);
    wr_reg(2'd3, 8'hFF); rd_reg(2'd3, v); check("R1 unused address", int'(v), 0);
    wr_reg(2'd1, 8'h00); wr_reg(2'd0, 8'h00);
    rd_reg(2'd2, v); check("R1 flags idle", int'(v), 0);

    // R6: flag latched with enable off
    pulse_upd();
    check("R6 no irq while disabled", int'(irq), 0);
    rd_reg(2'd2, v); check("R6 update flag latched", int'(v), 8'h10);
    // R8: read clears
    rd_reg(2'd2, v); check("R8 flags cleared by read", int'(v), 0);

    // R7: enabled source drives irq and summary bit
    wr_reg(2'd1, 8'h10);
    pulse_upd();
    check("R7 irq on enabled update", int'(irq), 1);
    rd_reg(2'd2, v); check("R7 summary and update flag", int'(v), 8'h90);
    check("R8 irq dropped after read", int'(irq), 0);

    // R9: event coincides with read
    wr_reg(2'd1, 8'h20);
    bus_addr = 2'd2; bus_rd = 1'b1; alarm_hit = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0; alarm_hit = 1'b0;
    check("R9 read returns old flags", int'(v), 0);
    check("R9 irq after collision", int'(irq), 1);
    rd_reg(2'd2, v); check("R9 alarm flag kept", int'(v), 8'hA0);

    // R10: level behaviour
    wr_reg(2'd1, 8'h00);
    pulse_alarm();
    check("R10 disabled alarm no irq", int'(irq), 0);
    wr_reg(2'd1, 8'h20);
    check("R10 enable raises irq", int'(irq), 1);
    wr_reg(2'd1, 8'h00);
    check("R10 disable lowers irq", int'(irq), 0);
    rd_reg(2'd2, v); check("R10 flag retained", int'(v), 8'h20);

    // R4: no strobe, no periodic event
    wr_reg(2'd1, 8'h40);
    base_tick = 1'b0;
    wr_reg(2'd0, 8'd3);
    rd_reg(2'd2, v);
    repeat (50) @(posedge clk);
    #1 check("R4 idle without strobe", int'(irq), 0);

    // R4: strobe every other cycle, rate code 3 -> 8 clocks
    wr_reg(2'd0, 8'd3);
    rd_reg(2'd2, v);
    n = 1;
    while (!irq && n < 100) begin
      base_tick = ((n + 1) % 2 == 0);
      @(posedge clk); #1;
      n++;
    end
    base_tick = 1'b0;
    check("R4 half-rate period", n, 8);

    // R2/R5: sweep all active rate codes with strobe every cycle
    base_tick = 1'b1;
    for (int code = 3; code < 16; code++) begin
      wr_reg(2'd0, 8'(code));
      rd_reg(2'd2, v);
      n = 1;
      while (!irq && n < 20000) begin @(posedge clk); #1; n++; end
      check("R5 first period after rate write", n, period_of(code));
      rd_reg(2'd2, v);
      n = 1;
      while (!irq && n < 20000) begin @(posedge clk); #1; n++; end
      check("R2 steady period", n, period_of(code));
    end

    // R3: silent codes
    for (int code = 0; code < 3; code++) begin
      wr_reg(2'd0, 8'(code));
      rd_reg(2'd2, v);
      repeat (17000) @(posedge clk);
      #1 check("R3 no irq on silent code", int'(irq), 0);
      rd_reg(2'd2, v); check("R3 no periodic flag", int'(v), 0);
    end
    base_tick = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule